// File: doc/BRIEF.md
# Serial I/Q Sample Receiver

This block is the serial sample input for one channel of a digital upconverter. It runs as the master of a three-wire link. It produces the serial clock strobe and a frame strobe, and it shifts baseband I and Q words in from one of four shared data lines. Each sample period starts with a sample-start pulse. The next serial clock pulse after that pulse opens a frame. Two 10-bit slot values, both counted from the frame pulse, mark the serial clock pulse that carries the last bit of I and the last bit of Q. The I and Q windows can therefore come in either order, and several channels can share one data line by using slots that do not overlap.

Each captured word is 4, 8, 12 or 16 bits long. It is placed at the top of a 16-bit holding register, and the bits below it are zero. When both words are complete, the block gives one valid pulse together with the I/Q pair. The serial clock rate has four settings: the system clock, a divided system clock, an external 32-per-sample strobe, or stopped. The frame strobe is held off unless one of three transmit enables allows it. Serial operation as a whole depends on a serial-mode enable.

Top module: `iq_serial_rx`

## Requirements
- R1: When `ser_en_i` is low, the block emits no frame strobe, forgets any sample-start it has seen and abandons a frame in progress.
- R2: The serial clock rate comes from `clk_cfg_i[5:4]`. Code 0 pulses `sclk_o` on every clock. Code 1 pulses it once every `clk_cfg_i[3:0]`+1 clocks. Code 2 pulses it one clock after each `x32_tick_i` pulse. Code 3 keeps `sclk_o` low.
- R3: A sample-start pulse arms the block. `fsync_o` is then high for exactly one `sclk_o` pulse: the first one in a later clock cycle. Nothing else arms the block, apart from R11.
- R4: A frame can open only while `tx_en_i`, `sw_tx_en_i` or `tx_indep_i` is high. An armed request waits until one of them is high.
- R5: The `sclk_o` pulse that carries `fsync_o` has index 0, and each later pulse adds one. A word of L bits is taken MSB first on pulses slot-L+1 through slot, where slot is `i_slot_i` or `q_slot_i`.
- R6: The I and Q windows are independent of each other. Q may come before I, and the two windows may overlap on the same line.
- R7: `word_len_i` selects 4, 8, 12 or 16 bits for codes 0 to 3. The received bits sit in the top bits of `i_data_o`/`q_data_o`, and the lower bits are zero.
- R8: `port_sel_i` chooses which bit of `sdata_i` is sampled. The other lines have no effect.
- R9: Once both words are complete, `pair_valid_o` is high for a single clock, one clock after the later last-bit pulse. `i_data_o` and `q_data_o` change only in that cycle, and they reset to zero.
- R10: If a new frame opens before a pair is complete, the partial pair is discarded and capture starts again at index 0.
- R11: In clock code 2, when both bits of `b2b_en_i` are set, a new frame opens on the first serial pulse after the previous pair completes, with no sample-start needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_en_i | input | 1 | Serial mode enable |
| clk_cfg_i | input | 6 | Serial clock mode [5:4] and divisor [3:0] |
| x32_tick_i | input | 1 | Serial rate strobe, 32 per sample period |
| b2b_en_i | input | 2 | Back-to-back enable pair |
| tx_en_i | input | 1 | Transmit enable pin |
| sw_tx_en_i | input | 1 | Software transmit enable |
| tx_indep_i | input | 1 | Allow requests without transmit enable |
| samp_start_i | input | 1 | Sample period start pulse |
| word_len_i | input | 2 | Word length code |
| port_sel_i | input | 2 | Data line select |
| i_slot_i | input | 10 | Index of last I bit |
| q_slot_i | input | 10 | Index of last Q bit |
| sdata_i | input | 4 | Serial data lines |
| sclk_o | output | 1 | Serial clock strobe |
| fsync_o | output | 1 | Frame strobe |
| i_data_o | output | 16 | Justified I word |
| q_data_o | output | 16 | Justified Q word |
| pair_valid_o | output | 1 | I/Q pair valid pulse |

## Verification
`sclk_o` is a registered strobe, so it goes high one clock after the rate source asks for it. `fsync_o` is driven combinationally and therefore sits in the same cycle as the serial pulse that opens the frame. `pair_valid_o` and the data words appear one clock after the edge that samples the later last bit. The bench model steps its state at every rising edge. It compares all outputs 5 ns after that edge, with inputs changing only on falling edges, so each output is checked in the cycle where it is due.

// File: rtl/iq_srx_pkg.sv
package iq_srx_pkg;
  typedef enum logic [1:0] {
    SCLK_FULL = 2'd0,
    SCLK_DIV  = 2'd1,
    SCLK_X32  = 2'd2,
    SCLK_OFF  = 2'd3
  } sclk_mode_e;

  localparam int unsigned N_LANES = 2;
endpackage

// File: rtl/iq_srx_sclk_gen.sv
module iq_srx_sclk_gen
  import iq_srx_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sclk_mode_e       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             x32_tick_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      unique case (mode_i)
        SCLK_FULL: begin
          div_q  <= '0;
          tick_q <= 1'b1;
        end
        SCLK_DIV: begin
          if (div_q == div_i) begin
            div_q  <= '0;
            tick_q <= 1'b1;
          end else begin
            div_q  <= div_q + DIV_W'(1);
            tick_q <= 1'b0;
          end
        end
        SCLK_X32: begin
          div_q  <= '0;
          tick_q <= x32_tick_i;
        end
        default: begin
          div_q  <= '0;
          tick_q <= 1'b0;
        end
      endcase
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/iq_srx_lane.sv
module iq_srx_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLOT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              live_i,
  input  logic              frame_i,
  input  logic [SLOT_W:0]   cur_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [1:0]        len_code_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned LEN_W = SLOT_W + 1;
  localparam int unsigned STEP  = DATA_W / 4;

  logic [DATA_W-1:0] sr_q, sr_n;
  logic              done_q, done_n;
  logic [LEN_W-1:0]  len, shamt, slot_x;
  logic              in_win;

  assign len    = (LEN_W'(len_code_i) + LEN_W'(1)) * LEN_W'(STEP);
  assign shamt  = LEN_W'(DATA_W) - len;
  assign slot_x = {1'b0, slot_i};
  // window: slot-len < cur <= slot
  assign in_win = (cur_i <= slot_x) && ((cur_i + len) > slot_x);

  always_comb begin
    sr_n   = frame_i ? '0 : sr_q;
    done_n = frame_i ? 1'b0 : done_q;
    if (live_i && in_win) sr_n = {sr_n[DATA_W-2:0], bit_i};
    if (live_i && (cur_i == slot_x)) done_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_n;
      done_q <= done_n;
    end
  end

  assign done_o = done_q;
  assign word_o = sr_q << shamt;
endmodule

// File: rtl/iq_serial_rx.sv
module iq_serial_rx
  import iq_srx_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SLOT_W  = 10,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned SEL_W  = $clog2(N_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_en_i,
  input  logic [DIV_W+1:0]   clk_cfg_i,
  input  logic               x32_tick_i,
  input  logic [1:0]         b2b_en_i,
  input  logic               tx_en_i,
  input  logic               sw_tx_en_i,
  input  logic               tx_indep_i,
  input  logic               samp_start_i,
  input  logic [1:0]         word_len_i,
  input  logic [SEL_W-1:0]   port_sel_i,
  input  logic [SLOT_W-1:0]  i_slot_i,
  input  logic [SLOT_W-1:0]  q_slot_i,
  input  logic [N_PORTS-1:0] sdata_i,
  output logic               sclk_o,
  output logic               fsync_o,
  output logic [DATA_W-1:0]  i_data_o,
  output logic [DATA_W-1:0]  q_data_o,
  output logic               pair_valid_o
);
  localparam int unsigned CUR_W = SLOT_W + 1;

  sclk_mode_e  mode;
  logic        tick, allow, b2b, frame, live, sbit, vld_n;
  logic        pend_q, act_q, vld_q;
  logic [CUR_W-1:0] pos_q, cur;
  logic [N_LANES-1:0] lane_done;
  logic [DATA_W-1:0]  lane_word [N_LANES];
  logic [SLOT_W-1:0]  lane_slot [N_LANES];
  logic [DATA_W-1:0]  i_q, q_q;

  assign mode = sclk_mode_e'(clk_cfg_i[DIV_W+1 -: 2]);

  iq_srx_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .div_i      (clk_cfg_i[DIV_W-1:0]),
    .x32_tick_i (x32_tick_i),
    .tick_o     (tick)
  );

  assign allow = tx_en_i | sw_tx_en_i | tx_indep_i;
  assign b2b   = (mode == SCLK_X32) && (&b2b_en_i);
  assign frame = tick && ser_en_i && allow && (pend_q || (b2b && !act_q));
  assign live  = tick && (frame || act_q);
  assign cur   = frame ? '0 : pos_q + CUR_W'(1);
  assign sbit  = sdata_i[port_sel_i];

  assign lane_slot[0] = i_slot_i;
  assign lane_slot[1] = q_slot_i;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    iq_srx_lane #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .live_i     (live),
      .frame_i    (frame),
      .cur_i      (cur),
      .slot_i     (lane_slot[g]),
      .len_code_i (word_len_i),
      .bit_i      (sbit),
      .done_o     (lane_done[g]),
      .word_o     (lane_word[g])
    );
  end

  assign vld_n = act_q && (&lane_done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      pos_q  <= '0;
      vld_q  <= 1'b0;
      i_q    <= '0;
      q_q    <= '0;
    end else begin
      vld_q <= vld_n;
      if (vld_n) begin
        i_q <= lane_word[0];
        q_q <= lane_word[1];
      end
      if (!ser_en_i)         act_q <= 1'b0;
      else if (frame)        act_q <= 1'b1;
      else if (vld_n)        act_q <= 1'b0;
      if (!ser_en_i)         pend_q <= 1'b0;
      else if (samp_start_i) pend_q <= 1'b1;
      else if (frame)        pend_q <= 1'b0;
      // saturate once past any reachable slot
      if (frame)                       pos_q <= '0;
      else if (live && !pos_q[CUR_W-1]) pos_q <= cur;
    end
  end

  assign sclk_o       = tick;
  assign fsync_o      = frame;
  assign pair_valid_o = vld_q;
  assign i_data_o     = i_q;
  assign q_data_o     = q_q;
endmodule

// File: rtl/iq_serial_rx_chk.sv
module iq_serial_rx_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DIV_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_en_i,
  input logic              tx_en_i,
  input logic              sw_tx_en_i,
  input logic              tx_indep_i,
  input logic [DIV_W+1:0]  clk_cfg_i,
  input logic              sclk_o,
  input logic              fsync_o,
  input logic              pair_valid_o,
  input logic [DATA_W-1:0] i_data_o,
  input logic [DATA_W-1:0] q_data_o
);
  p_fsync_on_sclk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> sclk_o);

  p_fsync_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> (tx_en_i || sw_tx_en_i || tx_indep_i));

  p_serial_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |-> !fsync_o);

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |=> !pair_valid_o);

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_o |-> ($stable(i_data_o) && $stable(q_data_o)));

  p_sclk_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clk_cfg_i[DIV_W+1 -: 2] == 2'd3) && ($past(clk_cfg_i[DIV_W+1 -: 2]) == 2'd3)) |-> !sclk_o);
endmodule

bind iq_serial_rx iq_serial_rx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ser_en_i     (ser_en_i),
  .tx_en_i      (tx_en_i),
  .sw_tx_en_i   (sw_tx_en_i),
  .tx_indep_i   (tx_indep_i),
  .clk_cfg_i    (clk_cfg_i),
  .sclk_o       (sclk_o),
  .fsync_o      (fsync_o),
  .pair_valid_o (pair_valid_o),
  .i_data_o     (i_data_o),
  .q_data_o     (q_data_o)
);

// File: tb/iq_serial_rx_tb_top.sv
module iq_serial_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_en = 1'b0, x32 = 1'b0, tx_en = 1'b0, sw_tx = 1'b0, indep = 1'b0, samp = 1'b0;
  logic [5:0]  clk_cfg = '0;
  logic [1:0]  b2b = '0, wlen = '0, psel = '0;
  logic [9:0]  islot = '0, qslot = '0;
  logic [3:0]  sdata = '0;
  logic        sclk, fsync, pvld;
  logic [15:0] idat, qdat;

  always #10 clk = ~clk;

  iq_serial_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(ser_en), .clk_cfg_i(clk_cfg),
    .x32_tick_i(x32), .b2b_en_i(b2b), .tx_en_i(tx_en), .sw_tx_en_i(sw_tx),
    .tx_indep_i(indep), .samp_start_i(samp), .word_len_i(wlen), .port_sel_i(psel),
    .i_slot_i(islot), .q_slot_i(qslot), .sdata_i(sdata), .sclk_o(sclk),
    .fsync_o(fsync), .i_data_o(idat), .q_data_o(qdat), .pair_valid_o(pvld));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int fs_cnt, vd_cnt, sc_cnt;
  int last_i, last_q;

  // stimulus generators
  int  samp_per = 0, x32_per = 0, cyc = 0;
  bit  rand_data = 1;
  logic [3:0] const_data = '0;

  // reference model state
  int m_tick, m_div, m_pend, m_act, m_pos, m_iacc, m_qacc, m_idn, m_qdn, m_vld, m_idat, m_qdat;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int m_frame();
    int allow, bb;
    allow = tx_en | sw_tx | indep;
    bb = (clk_cfg[5:4] == 2'd2) && (b2b == 2'b11);
    return (m_tick && ser_en && allow && (m_pend || (bb && !m_act))) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_div = 0; m_pend = 0; m_act = 0; m_pos = 0;
      m_iacc = 0; m_qacc = 0; m_idn = 0; m_qdn = 0; m_vld = 0; m_idat = 0; m_qdat = 0;
    end else begin
      int len, frm, live, cur, b, nv;
      len  = 4 * (int'(wlen) + 1);
      frm  = m_frame();
      live = m_tick && (frm || m_act);
      cur  = frm ? 0 : m_pos + 1;
      b    = sdata[psel];
      nv   = m_act && m_idn && m_qdn;
      if (nv) begin
        m_idat = (m_iacc << (16 - len)) & 'hFFFF;
        m_qdat = (m_qacc << (16 - len)) & 'hFFFF;
      end
      if (frm) begin m_iacc = 0; m_qacc = 0; m_idn = 0; m_qdn = 0; end
      if (live) begin
        if (cur <= int'(islot) && cur + len > int'(islot)) m_iacc = ((m_iacc << 1) | b) & 'hFFFF;
        if (cur <= int'(qslot) && cur + len > int'(qslot)) m_qacc = ((m_qacc << 1) | b) & 'hFFFF;
        if (cur == int'(islot)) m_idn = 1;
        if (cur == int'(qslot)) m_qdn = 1;
      end
      if (frm) m_pos = 0;
      else if (live && m_pos < 1024) m_pos = cur;
      if (!ser_en) m_act = 0; else if (frm) m_act = 1; else if (nv) m_act = 0;
      if (!ser_en) m_pend = 0; else if (samp) m_pend = 1; else if (frm) m_pend = 0;
      case (clk_cfg[5:4])
        2'd0: begin m_tick = 1; m_div = 0; end
        2'd1: if (m_div == int'(clk_cfg[3:0])) begin m_div = 0; m_tick = 1; end
              else begin m_div = (m_div + 1) & 15; m_tick = 0; end
        2'd2: begin m_tick = x32; m_div = 0; end
        default: begin m_tick = 0; m_div = 0; end
      endcase
      m_vld = nv;
    end
  end

  // compare every clock, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk(sclk == m_tick[0], "R2", "sclk_o", sclk, m_tick);
      chk(fsync == m_frame(), "R3", "fsync_o", fsync, m_frame());
      chk(pvld == m_vld[0], "R9", "pair_valid_o", pvld, m_vld);
      chk(idat == m_idat[15:0], "R5", "i_data_o", idat, m_idat);
      chk(qdat == m_qdat[15:0], "R6", "q_data_o", qdat, m_qdat);
      if (fsync) fs_cnt++;
      if (sclk) sc_cnt++;
      if (pvld) begin vd_cnt++; last_i = idat; last_q = qdat; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    samp  <= (samp_per != 0) && (cyc % samp_per == 0);
    x32   <= (x32_per != 0) && (cyc % x32_per == 0);
    sdata <= rand_data ? 4'($urandom) : const_data;
  end

  task automatic setup(input bit en, input logic [5:0] cc, input logic [1:0] wl,
                       input int is, input int qs, input int sp);
    @(negedge clk);
    ser_en = 1'b0; samp_per = 0;
    repeat (3) @(negedge clk);
    clk_cfg = cc; wlen = wl; islot = 10'(is); qslot = 10'(qs);
    samp_per = sp; ser_en = en;
    fs_cnt = 0; vd_cnt = 0; sc_cnt = 0; last_i = -1; last_q = -1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R9)
    chk(pvld == 1'b0 && fsync == 1'b0, "R9", "reset valid/fsync", {pvld, fsync}, 0);
    chk(idat == 16'h0 && qdat == 16'h0, "R9", "reset data", idat ^ qdat, 0);
    rst_n = 1'b1;
    sw_tx = 1'b1;

    // R5: full rate, 8-bit words, I then Q
    setup(1, 6'h00, 2'd1, 7, 15, 40); run(400);
    chk(vd_cnt >= 8, "R5", "pairs full rate", vd_cnt, 8);
    // R6: Q before I
    setup(1, 6'h00, 2'd1, 20, 3, 40); run(400);
    chk(vd_cnt >= 8, "R6", "pairs Q first", vd_cnt, 8);
    // R6: overlapping windows
    setup(1, 6'h00, 2'd3, 15, 17, 40); run(200);
    chk(vd_cnt >= 4, "R6", "pairs overlap", vd_cnt, 4);
    // R2: divided clock
    setup(1, 6'h12, 2'd2, 11, 23, 120); run(600);
    chk(vd_cnt >= 4, "R2", "pairs divided", vd_cnt, 4);
    // R2: x32 strobe
    x32_per = 3;
    setup(1, 6'h20, 2'd3, 15, 31, 96); run(480);
    chk(vd_cnt >= 4, "R2", "pairs x32", vd_cnt, 4);
    // R11: back-to-back without sample starts
    b2b = 2'b11;
    setup(1, 6'h20, 2'd3, 15, 31, 0); run(600);
    chk(vd_cnt >= 5, "R11", "b2b pairs", vd_cnt, 5);
    b2b = 2'b01;
    setup(1, 6'h20, 2'd3, 15, 31, 0); run(300);
    chk(fs_cnt == 0, "R11", "no b2b with one bit", fs_cnt, 0);
    b2b = 2'b00; x32_per = 0;
    // R4: transmit-enable gating
    sw_tx = 1'b0;
    setup(1, 6'h00, 2'd1, 7, 15, 40); run(300);
    chk(fs_cnt == 0, "R4", "fsync while disabled", fs_cnt, 0);
    tx_en = 1'b1; fs_cnt = 0; run(300);
    chk(fs_cnt >= 5, "R4", "fsync with pin", fs_cnt, 5);
    tx_en = 1'b0; indep = 1'b1; fs_cnt = 0; run(300);
    chk(fs_cnt >= 5, "R4", "fsync independent", fs_cnt, 5);
    indep = 1'b0; sw_tx = 1'b1;
    // R1: serial mode off
    setup(0, 6'h00, 2'd1, 7, 15, 40); run(300);
    chk(fs_cnt == 0 && vd_cnt == 0, "R1", "activity when off", fs_cnt + vd_cnt, 0);
    // R10: restart discards partial pairs
    setup(1, 6'h00, 2'd3, 30, 40, 10); run(300);
    chk(vd_cnt == 0, "R10", "pairs under restart", vd_cnt, 0);
    chk(fs_cnt >= 20, "R10", "restart frames", fs_cnt, 20);
    // R7: justification with constant ones
    rand_data = 0; const_data = 4'b0001;
    setup(1, 6'h00, 2'd0, 3, 7, 40); run(120);
    chk(last_i == 'hF000, "R7", "i 4-bit", last_i, 'hF000);
    chk(last_q == 'hF000, "R7", "q 4-bit", last_q, 'hF000);
    setup(1, 6'h00, 2'd2, 11, 23, 40); run(120);
    chk(last_i == 'hFFF0, "R7", "i 12-bit", last_i, 'hFFF0);
    // R8: port select
    psel = 2'd2; const_data = 4'b0100;
    setup(1, 6'h00, 2'd2, 11, 23, 40); run(120);
    chk(last_q == 'hFFF0, "R8", "selected line", last_q, 'hFFF0);
    const_data = 4'b1011;
    setup(1, 6'h00, 2'd2, 11, 23, 40); run(120);
    chk(last_i == 0, "R8", "other lines ignored", last_i, 0);
    psel = 2'd0; rand_data = 1;
    // R2: clock stopped
    setup(1, 6'h30, 2'd1, 7, 15, 40); run(200);
    chk(sc_cnt == 0, "R2", "sclk when stopped", sc_cnt, 0);
    finish_up();
  end
endmodule